// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block takes one command request at a time from a register-style front end. It waits until the card's command line, and when needed its data line, are no longer marked busy. It then works out the command flags, launches the command towards the command engine, and watches the controller's interrupt status bits until the command has completed, has failed, or has run out of time. The result is reported with a one-cycle done pulse and a 2-bit code. On any failure the block also pulses resets for the command-line and data-line logic.

All time is counted in pulses of a millisecond tick input, so the limits are in milliseconds on silicon and can be scaled down in simulation.

The wait for free lines uses an adaptive limit, and that limit is kept from one command to the next. Each time the wait runs out, the limit doubles until it reaches a ceiling. Once the limit can no longer grow, the command is issued even though the lines are still busy. Stop-transmission commands look only at the command line. Tuning-block commands complete on data-available rather than on response-done. A 136-bit response, whose CRC byte has been stripped, is realigned before it is handed back.

A request is taken only while the sequencer is idle; a request pulse that arrives at any other time is ignored.

Top module: `sd_cmd_issue_seq`

## Requirements
- R1: A command is not issued while `cmd_inhibit` is high. When data is attached, it is also held back while `data_inhibit` is high, except for the stop index (default 12), which ignores `data_inhibit`.
- R2: The free-line wait limit starts at LIMIT_INIT ticks. When the wait count reaches the limit and twice the limit is at most LIMIT_MAX, the limit doubles and `status_clear` pulses. When the limit cannot double, the command is issued regardless of the busy lines.
- R3: The limit reached is kept across commands, and each new wait starts from it. With the lines always busy and the limit already at LIMIT_MAX, the command issues after LIMIT_MAX ticks with no doubling pulse.
- R4: `issue_flags` are laid out as follows:
  - [1:0] holds the response kind: 0 none, 1 long (136-bit), 2 short, 3 short with busy.
  - [2] holds the CRC-check request.
  - [3] holds the index-check request.
  - [4] is set when data is attached.
- R5: For a short response with busy and attached data, success needs both `sts_rsp_done` and `sts_data_end`. In every other non-tuning case, `sts_rsp_done` alone is enough.
- R6: For the tuning indices (defaults 19 and 21), completion waits for `sts_data_avail` instead of `sts_rsp_done`, and flag bit [4] is forced to 1.
- R7: If completion has not been reached after RSP_TIMEOUT ticks from issue, the result is timeout.
- R8: If `sts_error` is seen, the result is comm error (2). If `sts_timeout` is also set at that moment, the result is timeout (1) instead.
- R9: When a command fails, `rst_cmd_line` and `rst_data_line` are high in the same cycle as `done`. When it succeeds, both stay low.
- R10: On success with a long response, output word n is raw word (3-n) shifted left by 8, ORed with the top byte of raw word (2-n) for n<3. Word n occupies bits [32n+31:32n] in both the raw input and the output. For other response kinds, word 0 is raw word 0 and the other words are 0.
- R11: `done` is a single-cycle pulse carrying `result` (0 ok, 1 timeout, 2 comm error). `status_clear` also pulses in the cycle `issue_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| req_valid | input | 1 | Start a command (taken when idle) |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp_type | input | 2 | Response kind (0 none, 1 long, 2 short, 3 short busy) |
| req_crc_chk | input | 1 | Ask for response CRC check |
| req_idx_chk | input | 1 | Ask for response index check |
| req_data | input | 1 | Data phase attached |
| cmd_inhibit | input | 1 | Command line busy |
| data_inhibit | input | 1 | Data line busy |
| sts_rsp_done | input | 1 | Response-complete status |
| sts_data_end | input | 1 | Data-end status |
| sts_data_avail | input | 1 | Data-available status |
| sts_error | input | 1 | Any error status |
| sts_timeout | input | 1 | Timeout error status |
| raw_rsp | input | 128 | Response words from the command engine |
| status_clear | output | 1 | Clear all pending status bits |
| issue_valid | output | 1 | Launch pulse to the command engine |
| issue_index | output | 6 | Launched index |
| issue_arg | output | 32 | Launched argument |
| issue_flags | output | 5 | Launched flags (see R4) |
| done | output | 1 | Completion pulse |
| result | output | 2 | Result code |
| rsp_words | output | 128 | Realigned response |
| rst_cmd_line | output | 1 | Command-line reset pulse |
| rst_data_line | output | 1 | Data-line reset pulse |

## Verification
`issue_valid` rises one cycle after the first cycle in which the lines read free. `done` rises one cycle after the cycle in which the completing status, error, or timer expiry is sampled. Waits measured in ticks may therefore land one tick either side of the nominal count. The bench drives inputs and samples outputs on falling edges. It polls for each pulse in bounded loops, and checks tick counts against a window of plus or minus one. Each "nothing happens" check holds a partial status for a fixed number of cycles that is well inside the response limit, then confirms that `done` never rose.

// File: rtl/sd_seq_pkg.sv
// Package: shared encodings of the command issue sequencer.
// Assumes: response kind and result codes match the brief's R4 and R11 values.
package sd_seq_pkg;
    typedef enum logic [1:0] {
        RSP_NONE       = 2'd0,
        RSP_LONG       = 2'd1,
        RSP_SHORT      = 2'd2,
        RSP_SHORT_BUSY = 2'd3
    } rsp_kind_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_COMM    = 2'd2
    } result_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_ISSUE,
        ST_WAIT_STAT,
        ST_FINISH
    } state_t;

    localparam int FLAG_W = 5;
endpackage

// File: rtl/sd_seq_limit.sv
// Module: adaptive free-line wait limit.
// Keeps a limit that survives between commands and a per-command tick count.
// Assumes: restart never coincides with busy; LIMIT_INIT <= LIMIT_MAX.
module sd_seq_limit #(
    parameter int LIMIT_INIT = 100,
    parameter int LIMIT_MAX  = 3200,
    parameter int TW         = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          busy,
    input  logic          tick,
    output logic          grow,
    output logic          give_up,
    output logic [TW-1:0] limit_q
);
    logic [TW-1:0] wait_q;
    logic          expired;
    logic          can_grow;

    assign expired  = busy && (wait_q >= limit_q);
    assign can_grow = ((limit_q << 1) <= TW'(LIMIT_MAX));
    assign grow     = expired && can_grow;
    assign give_up  = expired && !can_grow;

    // Limit register: doubles on each expiry that still fits under the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_q <= TW'(LIMIT_INIT);
        else if (grow)
            limit_q <= limit_q << 1;
    end

    // Wait counter: cleared per command, counts ticks while lines are busy.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            wait_q <= '0;
        else if (busy && tick && (wait_q != '1))
            wait_q <= wait_q + 1'b1;
    end

    p_limit_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_q >= TW'(LIMIT_INIT)) && (limit_q <= TW'(LIMIT_MAX)));
    p_limit_double_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grow |=> (limit_q == ($past(limit_q) << 1)));
    p_limit_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (limit_q == $past(limit_q)));
endmodule

// File: rtl/sd_seq_flags.sv
// Module: command flag and completion-mask builder (combinational).
// Assumes: inputs come from the latched request and stay stable during a command.
module sd_seq_flags
    import sd_seq_pkg::*;
#(
    parameter int STOP_IDX   = 12,
    parameter int TUNE_IDX_A = 19,
    parameter int TUNE_IDX_B = 21
) (
    input  logic [5:0]        idx,
    input  rsp_kind_t         kind,
    input  logic              crc_chk,
    input  logic              idx_chk,
    input  logic              data,
    output logic [FLAG_W-1:0] flags,
    output logic              need_rsp,
    output logic              need_end,
    output logic              need_avail,
    output logic              watch_data_line
);
    logic tune;

    // Decode special indices and assemble flags and the completion mask.
    always_comb begin
        tune            = (idx == 6'(TUNE_IDX_A)) || (idx == 6'(TUNE_IDX_B));
        flags           = {data || tune, idx_chk, crc_chk, kind};
        need_rsp        = !tune;
        need_avail      = tune;
        need_end        = (kind == RSP_SHORT_BUSY) && data;
        watch_data_line = data && (idx != 6'(STOP_IDX));
    end
endmodule

// File: rtl/sd_seq_rsp_fmt.sv
// Module: realigns a 136-bit response whose CRC byte was stripped.
// Assumes: word k of raw sits at bits [32k+31:32k].
module sd_seq_rsp_fmt #(
    parameter int WORDS = 4
) (
    input  logic [32*WORDS-1:0] raw,
    input  logic                long_rsp,
    output logic [32*WORDS-1:0] words
);
    for (genvar n = 0; n < WORDS; n++) begin : g_word
        localparam int SRC = WORDS - 1 - n;
        if (n < WORDS - 1) begin : g_mid
            // Shift the source word up a byte and pull in the next word's top byte.
            assign words[32*n +: 32] = long_rsp ?
                {raw[32*SRC +: 24], raw[32*(SRC-1) + 24 +: 8]} :
                ((n == 0) ? raw[31:0] : 32'h0);
        end else begin : g_last
            // The lowest source word has no lower neighbour.
            assign words[32*n +: 32] = long_rsp ? {raw[32*SRC +: 24], 8'h00} :
                                       ((n == 0) ? raw[31:0] : 32'h0);
        end
    end
endmodule

// File: rtl/sd_cmd_issue_seq.sv
// Module: SD command issue sequencer (top).
// Waits for free lines, issues one command, waits for completion status and
// reports ok / timeout / comm error. Time is counted in ms_tick pulses.
// Assumes: status inputs are level bits held by the status register until cleared.
module sd_cmd_issue_seq
    import sd_seq_pkg::*;
#(
    parameter int LIMIT_INIT  = 100,
    parameter int LIMIT_MAX   = 3200,
    parameter int RSP_TIMEOUT = 1000,
    parameter int STOP_IDX    = 12,
    parameter int TUNE_IDX_A  = 19,
    parameter int TUNE_IDX_B  = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ms_tick,
    input  logic         req_valid,
    input  logic [5:0]   req_index,
    input  logic [31:0]  req_arg,
    input  logic [1:0]   req_rsp_type,
    input  logic         req_crc_chk,
    input  logic         req_idx_chk,
    input  logic         req_data,
    input  logic         cmd_inhibit,
    input  logic         data_inhibit,
    input  logic         sts_rsp_done,
    input  logic         sts_data_end,
    input  logic         sts_data_avail,
    input  logic         sts_error,
    input  logic         sts_timeout,
    input  logic [127:0] raw_rsp,
    output logic         status_clear,
    output logic         issue_valid,
    output logic [5:0]   issue_index,
    output logic [31:0]  issue_arg,
    output logic [4:0]   issue_flags,
    output logic         done,
    output logic [1:0]   result,
    output logic [127:0] rsp_words,
    output logic         rst_cmd_line,
    output logic         rst_data_line
);
    localparam int TW = $clog2(2 * LIMIT_MAX + 1) + 1;
    localparam int RW = $clog2(RSP_TIMEOUT + 1) + 1;

    state_t      state_q;
    logic [5:0]  idx_q;
    logic [31:0] arg_q;
    rsp_kind_t   kind_q;
    logic        crc_q, ichk_q, data_q;
    logic [RW-1:0] rsp_t_q;
    result_t     res_q;
    logic        fail_q;
    logic [127:0] rsp_q;

    logic [FLAG_W-1:0] flags;
    logic need_rsp, need_end, need_avail, watch_data_line;
    logic lines_free, met, grow, give_up;
    logic [TW-1:0] limit_q;
    logic [127:0] fmt_words;

    sd_seq_flags #(
        .STOP_IDX(STOP_IDX), .TUNE_IDX_A(TUNE_IDX_A), .TUNE_IDX_B(TUNE_IDX_B)
    ) u_flags (
        .idx(idx_q), .kind(kind_q), .crc_chk(crc_q), .idx_chk(ichk_q), .data(data_q),
        .flags(flags), .need_rsp(need_rsp), .need_end(need_end),
        .need_avail(need_avail), .watch_data_line(watch_data_line)
    );

    assign lines_free = !cmd_inhibit && !(watch_data_line && data_inhibit);

    sd_seq_limit #(
        .LIMIT_INIT(LIMIT_INIT), .LIMIT_MAX(LIMIT_MAX), .TW(TW)
    ) u_limit (
        .clk(clk), .rst_n(rst_n),
        .restart((state_q == ST_IDLE) && req_valid),
        .busy((state_q == ST_WAIT_FREE) && !lines_free),
        .tick(ms_tick), .grow(grow), .give_up(give_up), .limit_q(limit_q)
    );

    sd_seq_rsp_fmt #(.WORDS(4)) u_fmt (
        .raw(raw_rsp), .long_rsp(kind_q == RSP_LONG), .words(fmt_words)
    );

    assign met = (!need_rsp   || sts_rsp_done) &&
                 (!need_end   || sts_data_end) &&
                 (!need_avail || sts_data_avail);

    // Sequencer: request latch, free-line wait, issue, status wait, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            arg_q   <= '0;
            kind_q  <= RSP_NONE;
            crc_q   <= 1'b0;
            ichk_q  <= 1'b0;
            data_q  <= 1'b0;
            rsp_t_q <= '0;
            res_q   <= RES_OK;
            fail_q  <= 1'b0;
            rsp_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    idx_q   <= req_index;
                    arg_q   <= req_arg;
                    kind_q  <= rsp_kind_t'(req_rsp_type);
                    crc_q   <= req_crc_chk;
                    ichk_q  <= req_idx_chk;
                    data_q  <= req_data;
                    state_q <= ST_WAIT_FREE;
                end
                ST_WAIT_FREE: if (lines_free || give_up) state_q <= ST_ISSUE;
                ST_ISSUE: begin
                    rsp_t_q <= '0;
                    state_q <= ST_WAIT_STAT;
                end
                ST_WAIT_STAT: begin
                    if (sts_error) begin
                        res_q   <= sts_timeout ? RES_TIMEOUT : RES_COMM;
                        fail_q  <= 1'b1;
                        state_q <= ST_FINISH;
                    end else if (met) begin
                        res_q   <= RES_OK;
                        fail_q  <= 1'b0;
                        rsp_q   <= fmt_words;
                        state_q <= ST_FINISH;
                    end else if (rsp_t_q >= RW'(RSP_TIMEOUT)) begin
                        res_q   <= RES_TIMEOUT;
                        fail_q  <= 1'b1;
                        state_q <= ST_FINISH;
                    end else if (ms_tick) begin
                        rsp_t_q <= rsp_t_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the sequencer state and latched request.
    always_comb begin
        issue_valid   = (state_q == ST_ISSUE);
        status_clear  = grow || issue_valid;
        issue_index   = idx_q;
        issue_arg     = arg_q;
        issue_flags   = flags;
        done          = (state_q == ST_FINISH);
        result        = res_q;
        rsp_words     = rsp_q;
        rst_cmd_line  = done && fail_q;
        rst_data_line = done && fail_q;
    end

    p_issue_after_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> $past(!cmd_inhibit || give_up));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_fail_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((result != RES_OK) == (rst_cmd_line && rst_data_line)));
    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result == RES_OK) && need_end) |-> $past(sts_data_end));
endmodule

// File: tb/sim_sd_cmd_issue_seq.sv
module sim_sd_cmd_issue_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic req_valid = 1'b0;
    logic [5:0] req_index = '0;
    logic [31:0] req_arg = '0;
    logic [1:0] req_rsp_type = '0;
    logic req_crc_chk = 1'b0, req_idx_chk = 1'b0, req_data = 1'b0;
    logic cmd_inhibit = 1'b0, data_inhibit = 1'b0;
    logic sts_rsp_done = 1'b0, sts_data_end = 1'b0, sts_data_avail = 1'b0;
    logic sts_error = 1'b0, sts_timeout = 1'b0;
    logic [127:0] raw_rsp = '0;
    logic status_clear, issue_valid, done, rst_cmd_line, rst_data_line;
    logic [5:0] issue_index;
    logic [31:0] issue_arg;
    logic [4:0] issue_flags;
    logic [1:0] result;
    logic [127:0] rsp_words;

    int total = 0, bad = 0, clr_cnt = 0, cyc = 0, tdiv = 0;

    always #2.5 clk = ~clk;

    sd_cmd_issue_seq #(.LIMIT_INIT(2), .LIMIT_MAX(16), .RSP_TIMEOUT(20)) u0 (.*);

    // Tick generator: one tick every 4 cycles.
    always @(negedge clk) begin
        tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
        ms_tick <= (tdiv == 3);
    end

    // Count clear pulses.
    always @(negedge clk) if (rst_n && status_clear) clr_cnt <= clr_cnt + 1;

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [5:0] idx, input logic [1:0] kind,
                             input bit crc, input bit ichk, input bit dat);
        @(negedge clk);
        req_index = idx; req_arg = {26'h0, idx}; req_rsp_type = kind;
        req_crc_chk = crc; req_idx_chk = ichk; req_data = dat;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_issue(output int ticks, output bit seen, input int limit);
        ticks = 0; seen = 0;
        for (int i = 0; i < limit; i++) begin
            if (issue_valid) begin seen = 1; break; end
            if (ms_tick) ticks++;
            @(negedge clk);
        end
    endtask

    task automatic wait_done(output int ticks, output bit seen, output logic [1:0] res,
                             output bit rc, output bit rd, input int limit);
        ticks = 0; seen = 0; res = '0; rc = 0; rd = 0;
        for (int i = 0; i < limit; i++) begin
            if (done) begin
                seen = 1; res = result; rc = rst_cmd_line; rd = rst_data_line;
                break;
            end
            if (ms_tick) ticks++;
            @(negedge clk);
        end
    endtask

    task automatic clear_sts();
        sts_rsp_done = 0; sts_data_end = 0; sts_data_avail = 0;
        sts_error = 0; sts_timeout = 0;
        @(negedge clk);
    endtask

    task automatic finish_ok(input string req);
        int t; bit s, rc, rd; logic [1:0] r;
        sts_rsp_done = 1'b1; sts_data_end = 1'b1; sts_data_avail = 1'b1;
        wait_done(t, s, r, rc, rd, 50);
        chk(s && r == 2'd0, req, r, 0);
        chk(!rc && !rd, "R9 no reset on success", {rc, rd}, 0);
        clear_sts();
    endtask

    task automatic t_reset();
        chk(!done && !issue_valid && !status_clear && !rst_cmd_line, "R11 reset state",
            {done, issue_valid, status_clear, rst_cmd_line}, 0);
    endtask

    // R2: always-busy first command: three doublings then forced issue at 16 ticks.
    task automatic t_grow();
        int t, c0; bit s;
        cmd_inhibit = 1'b1;
        c0 = clr_cnt;
        start_cmd(6'd17, 2'd2, 1, 1, 0);
        wait_issue(t, s, 400);
        @(negedge clk);
        chk(s, "R2 forced issue", s, 1);
        chk(t >= 14 && t <= 17, "R2 ticks to forced issue", t, 16);
        chk(clr_cnt - c0 == 4, "R2 clear pulses (3 grow + 1 issue, R11)", clr_cnt - c0, 4);
        cmd_inhibit = 1'b0;
        finish_ok("R2 completes");
    endtask

    // R3: limit kept at 16, no further doubling.
    task automatic t_persist();
        int t, c0; bit s;
        cmd_inhibit = 1'b1;
        c0 = clr_cnt;
        start_cmd(6'd17, 2'd2, 1, 1, 0);
        wait_issue(t, s, 400);
        @(negedge clk);
        chk(s && t >= 14 && t <= 17, "R3 issue after kept limit", t, 16);
        chk(clr_cnt - c0 == 1, "R3 no doubling pulse", clr_cnt - c0, 1);
        cmd_inhibit = 1'b0;
        finish_ok("R3 completes");
    endtask

    // R1: inhibit gating, stop index bypass of data line.
    task automatic t_inhibit();
        int t; bit s;
        data_inhibit = 1'b1;
        start_cmd(6'd18, 2'd2, 1, 1, 1);
        wait_issue(t, s, 20);
        chk(!s, "R1 held by data_inhibit", s, 0);
        data_inhibit = 1'b0;
        wait_issue(t, s, 5);
        chk(s, "R1 issues when data line free", s, 1);
        @(negedge clk);
        finish_ok("R1 completes");
        data_inhibit = 1'b1;
        start_cmd(6'd12, 2'd3, 1, 1, 1);
        wait_issue(t, s, 5);
        chk(s && issue_index == 6'd12, "R1 stop ignores data_inhibit", issue_index, 12);
        @(negedge clk);
        finish_ok("R1 stop completes");
        data_inhibit = 1'b0;
        cmd_inhibit = 1'b1;
        start_cmd(6'd13, 2'd2, 0, 0, 0);
        wait_issue(t, s, 20);
        chk(!s, "R1 held by cmd_inhibit", s, 0);
        cmd_inhibit = 1'b0;
        wait_issue(t, s, 5);
        chk(s, "R1 issues when cmd line free", s, 1);
        @(negedge clk);
        finish_ok("R1 cmd completes");
    endtask

    // R4: flag encodings.
    task automatic flag_case(input logic [5:0] idx, input logic [1:0] k, input bit crc,
                             input bit ic, input bit d, input logic [4:0] exp);
        int t; bit s;
        start_cmd(idx, k, crc, ic, d);
        wait_issue(t, s, 10);
        chk(s && issue_flags == exp, "R4 flags", issue_flags, exp);
        chk(issue_arg == {26'h0, idx}, "R4 argument", issue_arg, idx);
        @(negedge clk);
        finish_ok("R4 completes");
    endtask

    // R5: short busy with data needs both statuses.
    task automatic t_busy_data();
        int t; bit s, rc, rd; logic [1:0] r;
        start_cmd(6'd7, 2'd3, 1, 1, 1);
        wait_issue(t, s, 10);
        @(negedge clk);
        sts_rsp_done = 1'b1;
        wait_done(t, s, r, rc, rd, 30);
        chk(!s, "R5 rsp_done alone not enough", s, 0);
        sts_data_end = 1'b1;
        wait_done(t, s, r, rc, rd, 10);
        chk(s && r == 2'd0, "R5 ok with data_end", r, 0);
        clear_sts();
        start_cmd(6'd7, 2'd3, 1, 1, 0);
        wait_issue(t, s, 10);
        @(negedge clk);
        sts_rsp_done = 1'b1;
        wait_done(t, s, r, rc, rd, 10);
        chk(s && r == 2'd0, "R5 short busy without data", r, 0);
        clear_sts();
    endtask

    // R6: tuning index.
    task automatic t_tune();
        int t; bit s, rc, rd; logic [1:0] r;
        start_cmd(6'd19, 2'd2, 1, 1, 0);
        wait_issue(t, s, 10);
        chk(s && issue_flags[4], "R6 data flag forced", issue_flags, 5'b11110);
        @(negedge clk);
        sts_rsp_done = 1'b1;
        wait_done(t, s, r, rc, rd, 30);
        chk(!s, "R6 rsp_done ignored for tuning", s, 0);
        sts_data_avail = 1'b1;
        wait_done(t, s, r, rc, rd, 10);
        chk(s && r == 2'd0, "R6 ok on data_avail", r, 0);
        clear_sts();
    endtask

    // R7 and R9: response timeout.
    task automatic t_rsp_timeout();
        int t; bit s, rc, rd; logic [1:0] r;
        start_cmd(6'd8, 2'd2, 1, 1, 0);
        wait_issue(t, s, 10);
        @(negedge clk);
        wait_done(t, s, r, rc, rd, 200);
        chk(s && r == 2'd1, "R7 timeout result", r, 1);
        chk(t >= 19 && t <= 21, "R7 timeout ticks", t, 20);
        chk(rc && rd, "R9 resets on timeout", {rc, rd}, 3);
    endtask

    // R8 and R9: error statuses.
    task automatic t_err(input bit to, input logic [1:0] exp);
        int t; bit s, rc, rd; logic [1:0] r;
        start_cmd(6'd9, 2'd2, 1, 1, 0);
        wait_issue(t, s, 10);
        @(negedge clk);
        sts_error = 1'b1; sts_timeout = to; sts_rsp_done = 1'b1;
        wait_done(t, s, r, rc, rd, 10);
        chk(s && r == exp, "R8 error result", r, exp);
        chk(rc && rd, "R9 resets on error", {rc, rd}, 3);
        clear_sts();
    endtask

    // R10: response realignment.
    task automatic t_rsp(input logic [1:0] kind, input logic [127:0] exp);
        int t; bit s;
        raw_rsp = {32'h11223344, 32'h55667788, 32'h99AABBCC, 32'hDDEEFF01};
        start_cmd(6'd2, kind, 1, 0, 0);
        wait_issue(t, s, 10);
        @(negedge clk);
        finish_ok("R10 completes");
        chk(rsp_words == exp, "R10 response words", rsp_words[127:64], exp[127:64]);
        chk(rsp_words[63:0] == exp[63:0], "R10 response low words", rsp_words[63:0], exp[63:0]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grow();
        t_persist();
        t_inhibit();
        flag_case(6'd0, 2'd0, 0, 0, 0, 5'b00000);
        flag_case(6'd2, 2'd1, 1, 0, 0, 5'b00101);
        flag_case(6'd17, 2'd2, 1, 1, 1, 5'b11110);
        flag_case(6'd6, 2'd3, 1, 1, 0, 5'b01111);
        t_busy_data();
        t_tune();
        t_rsp_timeout();
        t_err(1'b0, 2'd2);
        t_err(1'b1, 2'd1);
        t_rsp(2'd1, {32'hEEFF0100, 32'hAABBCCDD, 32'h66778899, 32'h22334455});
        t_rsp(2'd2, {96'h0, 32'hDDEEFF01});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule